// File: doc/BRIEF.md
# Dual-view interrupt status unit

This block gathers two event sources of a network controller, a transmit-done event and a receive event, into a pending-status register. It drives one interrupt line toward the processor. Each source has its own enable. A global mask bit gates the line as a whole. Events arrive as single-cycle pulses on two input pins. Software reaches the block through a simple word-addressed register port with separate read and write strobes.

The pending bits can be read at two addresses. A read of the draining address returns the bits and empties the register in the same access. A read of the inspecting address returns the same bits and leaves them in place. Writing ones to the inspecting address raises the matching pending bits. Software uses this when it has drained the register, sees that more receive work remains, and wants the event back without waiting for hardware.

The line is produced by a two-state machine with the states LINE_QUIET and LINE_RAISED. The transition QUIET->RAISED is taken on a clock edge where the line request is true. The transition RAISED->QUIET is taken on an edge where the request is false. In every other case the machine stays in its state (QUIET->QUIET, RAISED->RAISED). The interrupt output is high exactly in LINE_RAISED.

Top module: `isu_irq_unit`

## Requirements
- R1: After reset, the pending bits, the enable register, the global mask and the interrupt output are all 0, and read data is 0.
- R2: A pulse on the transmit event input sets pending bit 3, and a pulse on the receive event input sets pending bit 2. Pending bits read back at bit positions 3 and 2; all other status bits read 0.
- R3: A read of word address 1 (draining view) returns the pending bits on the read data one cycle after the access, and leaves the pending register empty after that edge.
- R4: A read of word address 2 (inspecting view) returns the pending bits one cycle after the access and does not change them.
- R5: A write to word address 2 sets every implemented pending bit whose data bit is 1. Data bits of 0 have no effect. A write to word address 1 has no effect.
- R6: The interrupt output can be 1 only while bit 15 of the global mask register (word address 3) is 1.
- R7: One cycle after the request changes, the interrupt output equals mask bit 15 AND ((pending bit 3 AND enable bit 3) OR (pending bit 2 AND any of enable bits 2:0)). The enable register is word address 0.
- R8: An event that arrives in the same cycle as a draining read is pending after that read. The read data of that access does not include it.
- R9: Clearing an enable bit drops the interrupt output but keeps the pending bit.
- R10: A draining read returns 0 when no source is pending.
- R11: The enable register reads back bits 3:0 as written, with higher bits 0. The mask register reads back bit 15 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_evt_i | input | 1 | Transmit-done event pulse |
| rx_evt_i | input | 1 | Receive event pulse |
| addr_i | input | 2 | Register word address (0 enable, 1 draining status, 2 inspecting status, 3 global mask) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Interrupt line |

## Verification
Events are sent from the transmit source alone, from the receive source alone, and from both combined. Comparing the two read views after each event shows that one view empties the register and the other leaves it unchanged. Software-set writes with ones, with zeros, and to the wrong address show that only the inspecting view sets bits. The line is checked under every combination of mask on or off, transmit enable, and each receive enable bit, with a single enable bit set alone to show that any of the three receive enable bits is enough. An event placed in the same cycle as a draining read shows that the event is kept and is not part of the returned data.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int TX_BIT    = 3;
    localparam int RX_BIT    = 2;
    localparam int RX_EN_LO  = 0;
    localparam int GMASK_BIT = 15;
    localparam int EN_W      = TX_BIT + 1;
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE    = 2'd0,
        A_STAT_CLR  = 2'd1,
        A_STAT_PEEK = 2'd2,
        A_GMASK     = 2'd3
    } isu_addr_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/isu_pending.sv
module isu_pending
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic              clr,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] pend
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == TX_BIT || i == RX_BIT) begin : g_src
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    // a new event or a software set wins over a draining read
                    bit_q <= (bit_q & ~clr) | evt[i] | set_vec[i];
                end
            end
            assign pend[i] = bit_q;
        end else begin : g_none
            assign pend[i] = 1'b0;
        end
    end
endmodule

// File: rtl/isu_regs.sv
module isu_regs
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] pend,
    output logic [EN_W-1:0]   en_q,
    output logic              gmask_q,
    output logic              clr_rd,
    output logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] rdata
);
    isu_addr_e         sel;
    logic [DATA_W-1:0] rd_mux;

    assign sel     = isu_addr_e'(addr);
    assign clr_rd  = rd_en && (sel == A_STAT_CLR);
    assign set_vec = (wr_en && (sel == A_STAT_PEEK)) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            gmask_q <= 1'b0;
        end else if (wr_en) begin
            if (sel == A_ENABLE) en_q    <= wdata[EN_W-1:0];
            if (sel == A_GMASK)  gmask_q <= wdata[GMASK_BIT];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            A_ENABLE:    rd_mux[EN_W-1:0] = en_q;
            A_STAT_CLR:  rd_mux = pend;
            A_STAT_PEEK: rd_mux = pend;
            A_GMASK:     rd_mux[GMASK_BIT] = gmask_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/isu_line_fsm.sv
module isu_line_fsm
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pend,
    input  logic [EN_W-1:0]   en,
    input  logic              gmask,
    output logic              irq
);
    line_state_e state_q, state_d;
    logic        line_req;

    assign line_req = gmask &
                      ((pend[TX_BIT] & en[TX_BIT]) |
                       (pend[RX_BIT] & (|en[RX_BIT:RX_EN_LO])));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (line_req)  state_d = LINE_RAISED;
            LINE_RAISED: if (!line_req) state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/isu_irq_unit.sv
module isu_irq_unit
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_evt_i,
    input  logic              rx_evt_i,
    input  logic [1:0]        addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] evt_w, pend_w, set_w;
    logic [EN_W-1:0]   en_w;
    logic              gmask_w, clr_w;

    always_comb begin
        evt_w         = '0;
        evt_w[TX_BIT] = tx_evt_i;
        evt_w[RX_BIT] = rx_evt_i;
    end

    isu_pending #(.DATA_W(DATA_W)) u_pend (
        .clk(clk_i), .rst_n(rst_ni), .evt(evt_w), .clr(clr_w),
        .set_vec(set_w), .pend(pend_w)
    );

    isu_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk_i), .rst_n(rst_ni), .addr(addr_i), .wr_en(wr_en_i),
        .wdata(wdata_i), .rd_en(rd_en_i), .pend(pend_w), .en_q(en_w),
        .gmask_q(gmask_w), .clr_rd(clr_w), .set_vec(set_w), .rdata(rdata_o)
    );

    isu_line_fsm #(.DATA_W(DATA_W)) u_line (
        .clk(clk_i), .rst_n(rst_ni), .pend(pend_w), .en(en_w),
        .gmask(gmask_w), .irq(irq_o)
    );
endmodule

// File: rtl/isu_irq_checker.sv
module isu_irq_checker
    import isu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tx_evt_i,
    input logic              rx_evt_i,
    input logic [1:0]        addr_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] pend_w,
    input logic [EN_W-1:0]   en_w,
    input logic              gmask_w
);
    p_line_needs_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(gmask_w));

    p_drain_empties_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == A_STAT_CLR && !tx_evt_i && !rx_evt_i && !wr_en_i)
        |=> (pend_w == '0));

    p_drain_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == A_STAT_CLR) |=> (rdata_o == $past(pend_w)));

    p_peek_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == A_STAT_PEEK && !wr_en_i && !tx_evt_i && !rx_evt_i)
        |=> $stable(pend_w));

    p_event_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_evt_i |=> pend_w[TX_BIT]);

    p_undrained_stays_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_w[RX_BIT] && !(rd_en_i && addr_i == A_STAT_CLR)) |=> pend_w[RX_BIT]);
endmodule

bind isu_irq_unit isu_irq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_evt_i(tx_evt_i), .rx_evt_i(rx_evt_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .pend_w(pend_w), .en_w(en_w), .gmask_w(gmask_w)
);

// File: tb/isu_irq_unit_tb.sv
module isu_irq_unit_tb;
    localparam int DW = 32;
    localparam logic [1:0] AD_EN = 2'd0, AD_CLR = 2'd1, AD_PEEK = 2'd2, AD_MASK = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_evt = 1'b0, rx_evt = 1'b0;
    logic [1:0]    addr = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int compared = 0;
    int mismatched = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    isu_irq_unit #(.DATA_W(DW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
        .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
        .rdata_o(rdata), .irq_o(irq)
    );

    // monitor: a read strobe seen at an edge yields data checked at the next falling edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (rdata !== e) begin
                mismatched++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [DW-1:0] e, string t);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(logic t, logic r);
        tx_evt = t; rx_evt = r;
        @(negedge clk);
        tx_evt = 1'b0; rx_evt = 1'b0;
    endtask

    task automatic chk_irq(logic e, string t);
        compared++;
        if (irq !== e) begin
            mismatched++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk_irq(1'b0, "R1");
        compared++;
        if (rdata !== '0) begin
            mismatched++;
            $display("FAIL R1: rdata actual %h expected %h", rdata, 32'h0);
        end
        rd(AD_PEEK, 32'h0, "R1");
        rd(AD_EN,   32'h0, "R1");
        rd(AD_MASK, 32'h0, "R1");
        // R10 empty drain
        rd(AD_CLR, 32'h0, "R10");
        // R2 transmit, R4 inspecting read keeps, R3 drain
        pulse(1'b1, 1'b0);
        rd(AD_PEEK, 32'h8, "R2");
        rd(AD_PEEK, 32'h8, "R4");
        rd(AD_CLR,  32'h8, "R3");
        rd(AD_PEEK, 32'h0, "R3");
        // R2 receive
        pulse(1'b0, 1'b1);
        rd(AD_PEEK, 32'h4, "R2");
        rd(AD_CLR,  32'h4, "R3");
        // both at once
        pulse(1'b1, 1'b1);
        rd(AD_CLR, 32'hC, "R2");
        // R5 software set
        wr(AD_PEEK, 32'h4);
        rd(AD_PEEK, 32'h4, "R5");
        wr(AD_PEEK, 32'h0);
        rd(AD_PEEK, 32'h4, "R5");
        wr(AD_PEEK, 32'hFFFF_FFF8);
        rd(AD_PEEK, 32'hC, "R5");
        wr(AD_CLR, 32'h0);
        rd(AD_PEEK, 32'hC, "R5");
        rd(AD_CLR,  32'hC, "R3");
        wr(AD_CLR, 32'hC);
        rd(AD_PEEK, 32'h0, "R5");
        // R6 / R7 line behaviour
        pulse(1'b1, 1'b0);
        wr(AD_EN, 32'h8);
        cyc(1);
        chk_irq(1'b0, "R6");
        wr(AD_MASK, 32'h8000);
        cyc(1);
        chk_irq(1'b1, "R7");
        // R9 disabling masks but keeps pending
        wr(AD_EN, 32'h0);
        cyc(1);
        chk_irq(1'b0, "R9");
        rd(AD_PEEK, 32'h8, "R9");
        // R7 receive group enabled by a single low bit
        wr(AD_EN, 32'h1);
        cyc(1);
        chk_irq(1'b0, "R7");
        pulse(1'b0, 1'b1);
        cyc(1);
        chk_irq(1'b1, "R7");
        wr(AD_EN, 32'h2);
        cyc(1);
        chk_irq(1'b1, "R7");
        rd(AD_CLR, 32'hC, "R3");
        cyc(1);
        chk_irq(1'b0, "R7");
        // R8 event coincident with draining read
        wr(AD_EN, 32'h8);
        pulse(1'b0, 1'b1);
        addr = AD_CLR; rd_en = 1'b1; tx_evt = 1'b1;
        exp_q.push_back(32'h4); tag_q.push_back("R8");
        @(negedge clk);
        rd_en = 1'b0; tx_evt = 1'b0;
        rd(AD_PEEK, 32'h8, "R8");
        chk_irq(1'b1, "R8");
        // R6 mask off drops line
        wr(AD_MASK, 32'h0);
        cyc(1);
        chk_irq(1'b0, "R6");
        // R11 readback
        rd(AD_MASK, 32'h0, "R11");
        wr(AD_MASK, 32'hFFFF_FFFF);
        rd(AD_MASK, 32'h8000, "R11");
        rd(AD_EN, 32'h8, "R11");
        wr(AD_EN, 32'hFFFF_FFFF);
        rd(AD_EN, 32'hF, "R11");
        cyc(3);
        summary();
        $finish;
    end
endmodule